// File: doc/BRIEF.md
# EPP Host Access Unit

This unit sits between a host register bus and the peripheral side of a parallel port. It serves enhanced-parallel-port (EPP) address and data accesses. It holds the port's control register, and it can start a peripheral cycle only while that register is in the exact state the direction needs. A host access at the EPP data offset may be 8, 16 or 32 bits wide. The unit splits it into single-byte peripheral cycles, least significant byte first, and joins read bytes back in the same order.

Each byte cycle is a request/acknowledge exchange that carries an error flag. A byte fails in two cases: the peripheral acknowledges it with the error flag set, or no acknowledge arrives within a fixed number of clocks. A failed byte sets a sticky timeout flag and ends the host access at once, so the remaining bytes are not sent. Software sees the flag as bit 0 of the status register and clears it by writing a 1 to that bit. The host bus waits on a ready pulse, which comes either when the last byte has finished or when a byte has failed.

The upper address window holds the extended-mode registers, and so do all unmapped addresses. Reads there return 0xFF and writes there do nothing.

Top module: `epp_host_port`

## Requirements
- R1: After reset the control register reads 0xCC, status bit 0 (the timeout flag) reads 0, `epp_req` is low and `bus_ready` is low.
- R2: A write to offset 2 loads the control register with the written byte, with bits 7 and 6 forced to 1. A read of offset 2 returns the stored value. The control register changes on no other access.
- R3: A write to offset 3 (address cycle) or offset 4 (data cycle) starts peripheral cycles only if control AND 0x2F equals 0x04. In that pattern bit 5 (direction) is 0, bit 2 (init) is 1, and bits 3 (select), 1 (autofeed) and 0 (strobe) are 0. Any other control value drops the write, and no request is raised.
- R4: A read of offset 3 or 4 starts peripheral cycles only if control AND 0x2F equals 0x24. Any other control value starts no cycle, and the read returns all ones over the access width.
- R5: At offset 4, `bus_size` 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 moves 4 bytes. Bytes go in order from `bus_wdata[7:0]` upward, and read bytes fill `bus_rdata` from bit 0 upward. Accesses at any other offset move one byte, and `epp_addr_cycle` is 1 exactly for offset 3.
- R6: A byte fails when it is acknowledged with `epp_err` high, or when it gets no acknowledge within TIMEOUT_CYCLES clocks of its request. A failure sets the timeout flag, skips the remaining bytes and completes the access. Read bytes that were not received successfully read as 0xFF.
- R7: A read of offset 1 returns `periph_status_hi` in bits 7..1 and the timeout flag in bit 0.
- R8: A write to offset 1 with bit 0 set clears the timeout flag. A write with bit 0 clear leaves the flag unchanged.
- R9: Addresses with bit 10 set (the extended window), and addresses with any of bits 9..3 set, read as 0xFF. Writes to them change no state.
- R10: Every access gets exactly one `bus_ready` pulse, one clock wide, with `bus_rdata` valid during it. An access that starts no peripheral cycle completes on the second rising edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host access present; held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the port |
| bus_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-clock completion pulse |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| epp_req | output | 1 | Byte cycle request, held until acknowledge or timeout |
| epp_addr_cycle | output | 1 | 1 = address cycle, 0 = data cycle |
| epp_write | output | 1 | 1 = byte to peripheral, 0 = byte from peripheral |
| epp_wdata | output | 8 | Byte being written |
| epp_ack | input | 1 | One-clock acknowledge of the current byte |
| epp_err | input | 1 | Error qualifier, sampled with `epp_ack` |
| epp_rdata | input | 8 | Byte read, sampled with `epp_ack` |
| periph_status_hi | input | 7 | Peripheral status lines shown in status bits 7..1 |

## Verification
A wrong control value or a wrong gate comparison shows up on the very next EPP access. A request is raised that should not be, or one that should be raised is missing, and the missing one also turns a read that should carry data into all ones. A byte index that drifts shows up as swapped or repeated bytes on `epp_wdata`, or in the assembled `bus_rdata`, within the same access. A timeout flag that is set or cleared wrongly stays hidden until status is read. For that reason the stimulus reads status often, so that such an error shows up a few accesses after the event that caused it. A timeout counter with the wrong limit changes how long a hung byte stalls the bus, and that length is measured directly.

// File: rtl/epp_host_pkg.sv
`timescale 1ns/1ps
package epp_host_pkg;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = 8 * BUS_BYTES;

  localparam logic [2:0] OFS_STATUS   = 3'd1;
  localparam logic [2:0] OFS_CTRL     = 3'd2;
  localparam logic [2:0] OFS_EPP_ADDR = 3'd3;
  localparam logic [2:0] OFS_EPP_DATA = 3'd4;

  localparam logic [7:0] CTRL_RESET  = 8'hCC;
  localparam logic [7:0] CTRL_FORCED = 8'hC0;
  localparam logic [7:0] GATE_MASK   = 8'h2F;
  localparam logic [7:0] GATE_WRITE  = 8'h04;
  localparam logic [7:0] GATE_READ   = 8'h24;

  typedef enum logic [1:0] {SQ_IDLE, SQ_XFER, SQ_RESP} seq_state_e;

  // Number of peripheral bytes an access moves.
  function automatic logic [2:0] byte_span(input logic [1:0] size, input logic data_ofs);
    if (!data_ofs) return 3'd1;
    case (size)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // All-ones over the low nb bytes of the bus.
  function automatic logic [BUS_W-1:0] span_mask(input logic [2:0] nb);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int i = 0; i < BUS_BYTES; i++)
      if (i < int'(nb)) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  // Control pattern check for one direction.
  function automatic logic gate_open(input logic [7:0] ctrl, input logic is_read);
    return (ctrl & GATE_MASK) == (is_read ? GATE_READ : GATE_WRITE);
  endfunction
endpackage

// File: rtl/epp_host_regs.sv
`timescale 1ns/1ps
module epp_host_regs
  import epp_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_status,
  input  logic [7:0] wbyte,
  input  logic       fail_evt,
  input  logic [6:0] periph_status_hi,
  output logic [7:0] ctrl_q,
  output logic       tmo_flag,
  output logic [7:0] status_view
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (wr_ctrl) ctrl_q <= wbyte | CTRL_FORCED;
  end

  // A failure wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)                      tmo_flag <= 1'b0;
    else if (fail_evt)               tmo_flag <= 1'b1;
    else if (wr_status && wbyte[0])  tmo_flag <= 1'b0;
  end

  assign status_view = {periph_status_hi, tmo_flag};

  assert_fail_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> tmo_flag);
  assert_clear_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && wbyte[0] && !fail_evt) |=> !tmo_flag);
  assert_ctrl_only_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/epp_host_byte_engine.sv
`timescale 1ns/1ps
module epp_host_byte_engine #(
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ack,
  input  logic err,
  output logic byte_done,
  output logic byte_fail
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

  logic [CNT_W-1:0] wait_cnt;
  logic             expired;

  assign expired   = (wait_cnt == CNT_W'(TIMEOUT_CYCLES - 1));
  // An acknowledge on the last allowed clock still counts.
  assign byte_done = active && (ack || expired);
  assign byte_fail = active && (ack ? err : expired);

  always_ff @(posedge clk) begin
    if (!rst_n || !active || byte_done) wait_cnt <= '0;
    else                                wait_cnt <= wait_cnt + 1'b1;
  end

  assert_counter_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (wait_cnt == '0));
endmodule

// File: rtl/epp_host_seq.sv
`timescale 1ns/1ps
module epp_host_seq
  import epp_host_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              bus_ready,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [7:0]        ctrl_q,
  input  logic [7:0]        status_view,
  input  logic              byte_done,
  input  logic              byte_fail,
  input  logic [7:0]        epp_rdata,
  output logic              epp_req,
  output logic              epp_addr_cycle,
  output logic              epp_write,
  output logic [7:0]        epp_wdata,
  output logic              wr_ctrl,
  output logic              wr_status,
  output logic [7:0]        wbyte
);
  seq_state_e       state;
  logic [1:0]       idx;
  logic [2:0]       nbytes;
  logic [BUS_W-1:0] wbuf, rbuf, rbuf_next, resp_q, imm_rdata;
  logic             is_wr, is_addr;

  logic       in_low, is_epp, accept, launch, last_byte;
  logic [2:0] ofs, span;

  assign ofs    = bus_addr[2:0];
  assign in_low = !bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:3] == '0);
  assign is_epp = in_low && (ofs == OFS_EPP_ADDR || ofs == OFS_EPP_DATA);
  assign span   = byte_span(bus_size, ofs == OFS_EPP_DATA);
  assign accept = (state == SQ_IDLE) && bus_valid;
  assign launch = accept && is_epp && gate_open(ctrl_q, !bus_write);

  assign wr_ctrl   = accept && bus_write && in_low && (ofs == OFS_CTRL);
  assign wr_status = accept && bus_write && in_low && (ofs == OFS_STATUS);
  assign wbyte     = bus_wdata[7:0];

  always_comb begin
    imm_rdata = {{(BUS_W-8){1'b0}}, 8'hFF};
    if (bus_write)      imm_rdata = '0;
    else if (in_low) begin
      case (ofs)
        OFS_STATUS:   imm_rdata = {{(BUS_W-8){1'b0}}, status_view};
        OFS_CTRL:     imm_rdata = {{(BUS_W-8){1'b0}}, ctrl_q};
        OFS_EPP_ADDR,
        OFS_EPP_DATA: imm_rdata = span_mask(span);
        default:      imm_rdata = {{(BUS_W-8){1'b0}}, 8'hFF};
      endcase
    end
  end

  always_comb begin
    rbuf_next = rbuf;
    if (!is_wr && byte_done && !byte_fail)
      rbuf_next[{idx, 3'b000} +: 8] = epp_rdata;
  end

  assign last_byte = ({1'b0, idx} == (nbytes - 3'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      idx     <= '0;
      nbytes  <= 3'd1;
      wbuf    <= '0;
      rbuf    <= '1;
      is_wr   <= 1'b0;
      is_addr <= 1'b0;
      resp_q  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (launch) begin
            state   <= SQ_XFER;
            idx     <= '0;
            nbytes  <= span;
            wbuf    <= bus_wdata;
            rbuf    <= '1;
            is_wr   <= bus_write;
            is_addr <= (ofs == OFS_EPP_ADDR);
          end else if (accept) begin
            state  <= SQ_RESP;
            resp_q <= imm_rdata;
          end
        end
        SQ_XFER: begin
          rbuf <= rbuf_next;
          if (byte_done) begin
            if (byte_fail || last_byte) begin
              state  <= SQ_RESP;
              resp_q <= is_wr ? '0 : (rbuf_next & span_mask(nbytes));
            end else begin
              idx <= idx + 2'd1;
            end
          end
        end
        SQ_RESP: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign epp_req        = (state == SQ_XFER);
  assign epp_write      = is_wr;
  assign epp_addr_cycle = is_addr;
  assign epp_wdata      = wbuf[{idx, 3'b000} +: 8];
  assign bus_ready      = (state == SQ_RESP);
  assign bus_rdata      = resp_q;

  assert_ready_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (epp_req && !byte_done) |=> (epp_req && $stable(epp_wdata)));
  assert_fail_ends_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fail |=> (bus_ready && !epp_req));
endmodule

// File: rtl/epp_host_port.sv
`timescale 1ns/1ps
module epp_host_port
  import epp_host_pkg::*;
#(
  parameter int ADDR_W         = 11,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  output logic              epp_req,
  output logic              epp_addr_cycle,
  output logic              epp_write,
  output logic [7:0]        epp_wdata,
  input  logic              epp_ack,
  input  logic              epp_err,
  input  logic [7:0]        epp_rdata,
  input  logic [6:0]        periph_status_hi
);
  logic [7:0] ctrl_q, status_view, wbyte;
  logic       tmo_flag, wr_ctrl, wr_status, byte_done, byte_fail;

  epp_host_regs u_regs (
    .clk, .rst_n, .wr_ctrl, .wr_status, .wbyte,
    .fail_evt(byte_fail), .periph_status_hi,
    .ctrl_q, .tmo_flag, .status_view
  );

  epp_host_byte_engine #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_engine (
    .clk, .rst_n, .active(epp_req), .ack(epp_ack), .err(epp_err),
    .byte_done, .byte_fail
  );

  epp_host_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_size, .bus_wdata,
    .bus_ready, .bus_rdata, .ctrl_q, .status_view, .byte_done, .byte_fail,
    .epp_rdata, .epp_req, .epp_addr_cycle, .epp_write, .epp_wdata,
    .wr_ctrl, .wr_status, .wbyte
  );

  assert_gate_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (epp_req && epp_write) |-> ((ctrl_q & 8'h2F) == 8'h04));
  assert_gate_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (epp_req && !epp_write) |-> ((ctrl_q & 8'h2F) == 8'h24));
  assert_no_req_while_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> !epp_req);
endmodule

// File: tb/tb_epp_host_port.sv
`timescale 1ns/1ps
module tb_epp_host_port;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        epp_req, epp_addr_cycle, epp_write;
  logic [7:0]  epp_wdata;
  logic        epp_ack = 1'b0, epp_err = 1'b0;
  logic [7:0]  epp_rdata = 8'h00;
  logic [6:0]  pstat = 7'h55;

  epp_host_port #(.ADDR_W(11), .TIMEOUT_CYCLES(TMO)) dut (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_size, .bus_wdata,
    .bus_ready, .bus_rdata, .epp_req, .epp_addr_cycle, .epp_write, .epp_wdata,
    .epp_ack, .epp_err, .epp_rdata, .periph_status_hi(pstat)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Peripheral model: per-access behaviour and a log of acknowledged bytes.
  int pmode = 0, pfail = 0, pdelay = 1, pcount = 0, pwait = 0;
  logic [7:0] lw [0:7];
  logic [7:0] lr [0:7];
  bit         la [0:7];
  bit         le [0:7];
  bit         lwr[0:7];

  always @(negedge clk) begin
    if (epp_ack) begin
      epp_ack = 1'b0; epp_err = 1'b0; pwait = 0;
    end else if (epp_req) begin
      if (!(pmode == 2 && pcount == pfail)) begin
        pwait++;
        if (pwait >= pdelay && pcount < 8) begin
          epp_ack   = 1'b1;
          epp_err   = (pmode == 1 && pcount == pfail);
          epp_rdata = 8'($urandom);
          lw[pcount]  = epp_wdata;
          lr[pcount]  = epp_rdata;
          la[pcount]  = epp_addr_cycle;
          le[pcount]  = epp_err;
          lwr[pcount] = epp_write;
          pcount++;
        end
      end
    end else begin
      pwait = 0;
    end
  end

  int last_cyc;

  task automatic access(input bit wr, input logic [10:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    int g;
    pcount = 0; pwait = 0;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!bus_ready && g < 500);
    rd = bus_rdata;
    last_cyc = g;
    bus_valid = 1'b0;
  endtask

  // Bench-side model of the requirements.
  logic [7:0] ctrl_m = 8'hCC;
  bit         flag_m = 1'b0;

  function automatic int bytes_of(input logic [10:0] a, input logic [1:0] sz);
    if (a[10:3] != 8'd0 || a[2:0] != 3'd4) return 1;
    return (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
  endfunction

  function automatic logic [31:0] ones_of(input int n);
    return (n == 1) ? 32'h0000_00FF : ((n == 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF);
  endfunction

  function automatic bit gate_ok(input logic [7:0] c, input bit wr);
    return (c & 8'h2F) == (wr ? 8'h04 : 8'h24);
  endfunction

  task automatic op(input bit wr, input logic [10:0] a, input logic [1:0] sz,
                    input logic [31:0] wd, input int mode, input int f, input int dly);
    logic [31:0] rd, exp;
    bit low, epp, go;
    int n, expn, good;
    string tg;
    pmode = mode; pfail = f; pdelay = dly;
    low = (a[10:3] == 8'd0);
    epp = low && (a[2:0] == 3'd3 || a[2:0] == 3'd4);
    n   = bytes_of(a, sz);
    go  = epp && gate_ok(ctrl_m, wr);
    access(wr, a, sz, wd, rd);
    expn = 0;
    if (go) expn = (mode == 0) ? n : ((mode == 1) ? ((f + 1 < n) ? f + 1 : n) : ((f < n) ? f : n));
    tg = !epp ? "R9 no cycle outside EPP offsets" : (!go ? (wr ? "R3 gated write" : "R4 gated read")
         : (mode != 0 && f < n) ? "R6 failed byte count" : "R5 byte count");
    chk(pcount == expn, tg, 32'(pcount), 32'(expn));
    for (int i = 0; i < pcount && i < 8; i++) begin
      chk(la[i] == (a[2:0] == 3'd3), "R5 address-cycle flag", 32'(la[i]), 32'(a[2:0] == 3'd3));
      chk(lwr[i] == wr, "R5 direction", 32'(lwr[i]), 32'(wr));
      if (wr) chk(lw[i] == wd[8*i +: 8], "R5 write byte order", 32'(lw[i]), 32'(wd[8*i +: 8]));
    end
    if (!wr) begin
      if (!low)                 exp = 32'hFF;
      else if (a[2:0] == 3'd1)  exp = {24'd0, pstat, flag_m};
      else if (a[2:0] == 3'd2)  exp = {24'd0, ctrl_m};
      else if (epp && !go)      exp = ones_of(n);
      else if (epp) begin
        good = 0;
        while (good < pcount && !le[good]) good++;
        exp = 32'd0;
        for (int i = 0; i < n; i++) exp[8*i +: 8] = (i < good) ? lr[i] : 8'hFF;
      end else exp = 32'hFF;
      tg = (low && a[2:0] == 3'd1) ? "R7 status read" : (low && a[2:0] == 3'd2) ? "R2 control read"
           : !low ? "R9 outside window read" : (epp && !go) ? "R4 gated read data" : "R5 read assembly";
      chk(rd == exp, tg, rd, exp);
    end
    if (go && mode != 0 && f < n) flag_m = 1'b1;
    if (wr && low && a[2:0] == 3'd2) ctrl_m = wd[7:0] | 8'hC0;
    if (wr && low && a[2:0] == 3'd1 && wd[0]) flag_m = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    op(1'b1, 11'h002, 2'd0, {24'd0, v}, 0, 0, 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(bus_ready == 1'b0, "R1 ready low after reset", 32'(bus_ready), 32'd0);
    chk(epp_req == 1'b0, "R1 no request after reset", 32'(epp_req), 32'd0);
    access(1'b0, 11'h002, 2'd0, 32'd0, rd);
    chk(rd == 32'hCC, "R1 control reset value", rd, 32'hCC);
    access(1'b0, 11'h001, 2'd0, 32'd0, rd);
    chk(rd[0] == 1'b0, "R1 timeout flag clear after reset", 32'(rd[0]), 32'd0);
    chk(last_cyc == 1, "R10 immediate access latency", 32'(last_cyc), 32'd1);

    // R3/R4: gate closed at reset value
    op(1'b1, 11'h004, 2'd2, 32'hDEADBEEF, 0, 0, 1);
    op(1'b0, 11'h004, 2'd2, 32'd0, 0, 0, 1);
    op(1'b0, 11'h004, 2'd1, 32'd0, 0, 0, 1);

    // R2: forced bits
    wr_ctrl(8'h04);
    op(1'b0, 11'h002, 2'd0, 32'd0, 0, 0, 1);
    // R5: 32-bit write order, then address byte
    op(1'b1, 11'h004, 2'd2, 32'h11223344, 0, 0, 2);
    op(1'b1, 11'h003, 2'd2, 32'hAABBCC5A, 0, 0, 1);
    op(1'b0, 11'h004, 2'd0, 32'd0, 0, 0, 1);   // R4 read while write pattern
    wr_ctrl(8'h0C);                              // R3 select set closes writes
    op(1'b1, 11'h004, 2'd0, 32'h77, 0, 0, 1);
    wr_ctrl(8'h24);
    op(1'b0, 11'h004, 2'd1, 32'd0, 0, 0, 3);    // R5 16-bit read
    op(1'b0, 11'h003, 2'd0, 32'd0, 0, 0, 1);
    op(1'b1, 11'h004, 2'd2, 32'h1, 0, 0, 1);    // R3 write while read pattern

    // R6: error on byte 1 of a 32-bit read, ack just inside the limit
    op(1'b0, 11'h004, 2'd2, 32'd0, 1, 1, TMO - 1);
    op(1'b0, 11'h001, 2'd0, 32'd0, 0, 0, 1);    // R7 flag visible
    op(1'b1, 11'h001, 2'd0, 32'hFE, 0, 0, 1);   // R8 bit0 clear keeps flag
    op(1'b0, 11'h001, 2'd0, 32'd0, 0, 0, 1);
    op(1'b1, 11'h001, 2'd0, 32'h01, 0, 0, 1);   // R8 clears
    op(1'b0, 11'h001, 2'd0, 32'd0, 0, 0, 1);

    // R6: hung byte 0 times out
    op(1'b0, 11'h004, 2'd0, 32'd0, 2, 0, 1);
    chk(last_cyc >= TMO && last_cyc <= TMO + 2, "R6 timeout stall length", 32'(last_cyc), 32'(TMO + 1));
    op(1'b0, 11'h001, 2'd0, 32'd0, 0, 0, 1);

    // R9: extended window and unmapped
    op(1'b0, 11'h404, 2'd2, 32'd0, 0, 0, 1);
    op(1'b1, 11'h402, 2'd0, 32'h00, 0, 0, 1);
    op(1'b1, 11'h00A, 2'd0, 32'h00, 0, 0, 1);
    op(1'b0, 11'h002, 2'd0, 32'd0, 0, 0, 1);

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      logic [10:0] a;
      logic [31:0] wd;
      int m, r;
      bit wr;
      pstat = 7'($urandom);
      case ($urandom % 11)
        0: a = 11'h000; 1: a = 11'h001; 2: a = 11'h002; 3: a = 11'h003;
        4, 5, 6: a = 11'h004; 7: a = 11'h404; 8: a = 11'h403; 9: a = 11'h00C;
        default: a = 11'h001;
      endcase
      wr = 1'($urandom);
      wd = $urandom;
      if (a == 11'h002 && wr) begin
        case ($urandom % 6)
          0: wd[7:0] = 8'h04; 1: wd[7:0] = 8'h24; 2: wd[7:0] = 8'h14;
          3: wd[7:0] = 8'h34; 4: wd[7:0] = 8'h2C; default: ;
        endcase
      end
      r = $urandom % 10;
      m = (r < 6) ? 0 : ((r < 8) ? 1 : 2);
      op(wr, a, 2'($urandom), wd, m, $urandom % 4, 1 + ($urandom % (TMO - 2)));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule